// File: doc/BRIEF.md
# Double-Buffered Stream Address Controller

This block keeps the memory addresses for two audio sample streams, one inbound and one outbound. Each stream has a working pointer and a queued pointer. While a stream runs, every frame strobe from the frame engine moves its address forward by one frame's worth of bytes. After a programmed number of frames, the buffer is finished and the queued pointer becomes the new working pointer. Software keeps the streams going by writing a fresh queued pointer once each buffer has started.

Software does not swap the pointers; the block swaps them itself at the buffer boundary. If the queued pointer is still empty when a buffer ends, that is a fatal starvation. The block sets an error flag, stops both streams and zeroes every pointer. This is also the normal way to shut down in order: stop refilling, wait for the error, and then find all four pointers reading zero. Completions, starvation and three error events from outside the block are collected in a flag register. A mask register selects which flags drive the interrupt line.

Software reaches the block through a simple register port with one address. Writes take effect at the clock edge. The read data appears one cycle after the address is presented.

Top module: `bufptr_ctrl`

## Requirements
- R1: After reset, the length register (offset 0), both queued pointers (offsets 2 and 3), both working pointers (offsets 4 and 5), the flags (offset 6) and the mask (offset 7) read zero. Both address outputs are zero, and `running` and `irq` are low. `reg_rdata` shows the register at `reg_addr` one cycle after the address is presented.
- R2: Writing a nonzero length to offset 0 while stopped starts both streams. Each working pointer and address output takes the value of its queued pointer, and both queued pointers become zero.
- R3: While running, each frame strobe advances a stream's address by its channel count times the word size. The format register is at offset 1: bits 3:0 hold the inbound channel count and bits 7:4 the outbound channel count. Bit 8 selects a 3-byte word when 1 and a 2-byte word when 0.
- R4: On the strobe that completes the programmed number of frames, the stream loads its queued pointer into the working pointer and the address output, and the queued pointer becomes zero. The block then sets the done flag: bit 4 for outbound and bit 5 for inbound. A queued-pointer write in that same cycle counts as an in-time refill, and the written value is the one used.
- R5: If a stream's queued pointer is zero when its buffer completes, the block sets flag bit 0 and the length becomes zero (both streams stop). All four pointers and both address outputs become zero.
- R6: A stream whose channel count is zero does not advance, does not swap and never reports starvation.
- R7: Writing zero to the length stops both streams at once. Frame strobes are then ignored and the address outputs hold.
- R8: Pulses on `err_fclk`, `err_bus` and `err_timeout` set flag bits 1, 2 and 3.
- R9: Writing ones to offset 8 clears the matching flags. A flag that is set in the same cycle stays set.
- R10: Offset 9 reads the flags ANDed with the mask. `irq` is high exactly when that value is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| frame_tick | input | 1 | One-cycle strobe per sample frame |
| err_fclk | input | 1 | Frame clock error event |
| err_bus | input | 1 | Memory bus error event |
| err_timeout | input | 1 | Timeout event |
| in_addr | output | 32 | Current inbound sample address |
| out_addr | output | 32 | Current outbound sample address |
| running | output | 1 | Streams active (length nonzero) |
| irq | output | 1 | Interrupt request |

## Verification
Two collisions matter most. The first is a software refill of the queued pointer landing in the same cycle as the buffer-ending strobe. The bench drives the write and the strobe together and expects a clean swap to the written address with no error. The second is a flag clear that coincides with a starvation. The bench writes the clear register on the final strobe of an unrefilled buffer and expects the error flag to survive while the done flag named in the same clear goes away. Randomized runs vary the channel counts, word size, buffer length and buffer count. Each run ends in a deliberate starvation, and the bench predicts every address and the final flag pattern.

// File: rtl/bufptr_pkg.sv
package bufptr_pkg;

  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] RA_LEN     = 4'd0;
  localparam logic [REG_AW-1:0] RA_FMT     = 4'd1;
  localparam logic [REG_AW-1:0] RA_IN_NXT  = 4'd2;
  localparam logic [REG_AW-1:0] RA_OUT_NXT = 4'd3;
  localparam logic [REG_AW-1:0] RA_IN_CUR  = 4'd4;
  localparam logic [REG_AW-1:0] RA_OUT_CUR = 4'd5;
  localparam logic [REG_AW-1:0] RA_FLAGS   = 4'd6;
  localparam logic [REG_AW-1:0] RA_MASK    = 4'd7;
  localparam logic [REG_AW-1:0] RA_CLEAR   = 4'd8;
  localparam logic [REG_AW-1:0] RA_MASKED  = 4'd9;

  localparam int FLAG_W      = 6;
  localparam int FB_STARVE   = 0;
  localparam int FB_FCLK     = 1;
  localparam int FB_BUS      = 2;
  localparam int FB_TMO      = 3;
  localparam int FB_OUT_DONE = 4;
  localparam int FB_IN_DONE  = 5;

  localparam int DIR_IN  = 0;
  localparam int DIR_OUT = 1;
  localparam int NDIR    = 2;

endpackage

// File: rtl/bufptr_lane.sv
module bufptr_lane #(
  parameter int AW    = 32,
  parameter int LEN_W = 16,
  parameter int CH_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic             frame,
  input  logic             kill,
  input  logic [CH_W-1:0]  chans,
  input  logic             wide,
  input  logic [LEN_W-1:0] len,
  input  logic             nxt_we,
  input  logic [AW-1:0]    nxt_wdata,
  output logic [AW-1:0]    cur_q,
  output logic [AW-1:0]    nxt_q,
  output logic [AW-1:0]    addr_q,
  output logic             done,
  output logic             starve
);

  logic [LEN_W-1:0] cnt_q;
  logic [AW-1:0]    step;
  logic [AW-1:0]    eff_nxt;
  logic             active;
  logic             tick;
  logic             last;
  logic             fin;

  assign active  = (chans != '0);
  assign step    = wide ? (AW'(chans) + AW'(chans) + AW'(chans)) : (AW'(chans) << 1);
  assign eff_nxt = nxt_we ? nxt_wdata : nxt_q;
  assign tick    = run & frame & active & ~start;
  assign last    = (cnt_q == LEN_W'(len - 1'b1));
  assign fin     = tick & last;
  assign done    = fin & (eff_nxt != '0);
  assign starve  = fin & (eff_nxt == '0);

  always_ff @(posedge clk) begin
    if (rst || kill) begin
      cur_q  <= '0;
      nxt_q  <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (start || done) begin
      cur_q  <= eff_nxt;
      addr_q <= eff_nxt;
      nxt_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (nxt_we) nxt_q <= nxt_wdata;
      if (tick) begin
        addr_q <= addr_q + step;
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/bufptr_irq.sv
module bufptr_irq #(
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] set,
  input  logic          clr_we,
  input  logic [FW-1:0] clr_bits,
  input  logic          mask_we,
  input  logic [FW-1:0] mask_wdata,
  output logic [FW-1:0] flags_q,
  output logic [FW-1:0] mask_q,
  output logic          irq_q
);

  logic [FW-1:0] flags_d;
  logic [FW-1:0] mask_d;

  always_comb begin
    flags_d = (flags_q & ~(clr_we ? clr_bits : '0)) | set;
    mask_d  = mask_we ? mask_wdata : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      mask_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      mask_q  <= mask_d;
      irq_q   <= |(flags_d & mask_d);
    end
  end

endmodule

// File: rtl/bufptr_ctrl.sv
module bufptr_ctrl
  import bufptr_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LEN_W = 16,
  parameter int CH_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              frame_tick,
  input  logic              err_fclk,
  input  logic              err_bus,
  input  logic              err_timeout,
  output logic [AW-1:0]     in_addr,
  output logic [AW-1:0]     out_addr,
  output logic              running,
  output logic              irq
);

  localparam int FMT_W = 2 * CH_W + 1;

  logic [LEN_W-1:0]  len_q;
  logic [FMT_W-1:0]  fmt_q;
  logic              start;
  logic              kill;
  logic [AW-1:0]     cur_v  [NDIR];
  logic [AW-1:0]     nxt_v  [NDIR];
  logic [AW-1:0]     addr_v [NDIR];
  logic [NDIR-1:0]   done_v;
  logic [NDIR-1:0]   starve_v;
  logic [FLAG_W-1:0] flag_set;
  logic [FLAG_W-1:0] flags;
  logic [FLAG_W-1:0] mask;
  logic [DW-1:0]     rd_mux;
  logic              wr_len;

  assign wr_len  = reg_we && (reg_addr == RA_LEN);
  assign start   = wr_len && (reg_wdata[LEN_W-1:0] != '0) && (len_q == '0);
  assign kill    = |starve_v;
  assign running = (len_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
      fmt_q <= '0;
    end else begin
      if (kill)        len_q <= '0;
      else if (wr_len) len_q <= reg_wdata[LEN_W-1:0];
      if (reg_we && reg_addr == RA_FMT) fmt_q <= reg_wdata[FMT_W-1:0];
    end
  end

  for (genvar d = 0; d < NDIR; d++) begin : g_lane
    localparam logic [REG_AW-1:0] NXT_RA = (d == DIR_IN) ? RA_IN_NXT : RA_OUT_NXT;
    bufptr_lane #(.AW(AW), .LEN_W(LEN_W), .CH_W(CH_W)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .run      (running),
      .frame    (frame_tick),
      .kill     (kill),
      .chans    (fmt_q[d*CH_W +: CH_W]),
      .wide     (fmt_q[2*CH_W]),
      .len      (len_q),
      .nxt_we   (reg_we && reg_addr == NXT_RA),
      .nxt_wdata(reg_wdata[AW-1:0]),
      .cur_q    (cur_v[d]),
      .nxt_q    (nxt_v[d]),
      .addr_q   (addr_v[d]),
      .done     (done_v[d]),
      .starve   (starve_v[d])
    );
  end

  always_comb begin
    flag_set              = '0;
    flag_set[FB_STARVE]   = kill;
    flag_set[FB_FCLK]     = err_fclk;
    flag_set[FB_BUS]      = err_bus;
    flag_set[FB_TMO]      = err_timeout;
    flag_set[FB_OUT_DONE] = done_v[DIR_OUT];
    flag_set[FB_IN_DONE]  = done_v[DIR_IN];
  end

  bufptr_irq #(.FW(FLAG_W)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .set       (flag_set),
    .clr_we    (reg_we && reg_addr == RA_CLEAR),
    .clr_bits  (reg_wdata[FLAG_W-1:0]),
    .mask_we   (reg_we && reg_addr == RA_MASK),
    .mask_wdata(reg_wdata[FLAG_W-1:0]),
    .flags_q   (flags),
    .mask_q    (mask),
    .irq_q     (irq)
  );

  always_comb begin
    case (reg_addr)
      RA_LEN:     rd_mux = DW'(len_q);
      RA_FMT:     rd_mux = DW'(fmt_q);
      RA_IN_NXT:  rd_mux = DW'(nxt_v[DIR_IN]);
      RA_OUT_NXT: rd_mux = DW'(nxt_v[DIR_OUT]);
      RA_IN_CUR:  rd_mux = DW'(cur_v[DIR_IN]);
      RA_OUT_CUR: rd_mux = DW'(cur_v[DIR_OUT]);
      RA_FLAGS:   rd_mux = DW'(flags);
      RA_MASK:    rd_mux = DW'(mask);
      RA_MASKED:  rd_mux = DW'(flags & mask);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  assign in_addr  = addr_v[DIR_IN];
  assign out_addr = addr_v[DIR_OUT];

endmodule

// File: rtl/bufptr_ctrl_chk.sv
module bufptr_ctrl_chk
  import bufptr_pkg::*;
#(
  parameter int AW = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic              running,
  input logic              kill,
  input logic [NDIR-1:0]   done_v,
  input logic [AW-1:0]     in_cur,
  input logic [AW-1:0]     out_cur,
  input logic [AW-1:0]     in_nxt,
  input logic [AW-1:0]     out_nxt,
  input logic [AW-1:0]     in_addr,
  input logic [AW-1:0]     out_addr,
  input logic [FLAG_W-1:0] flags,
  input logic [FLAG_W-1:0] mask,
  input logic              irq
);

  assert_drain_R5: assert property (@(posedge clk) disable iff (rst)
    kill |=> (in_cur == '0 && out_cur == '0 && in_nxt == '0 && out_nxt == '0 &&
              in_addr == '0 && out_addr == '0 && !running && flags[FB_STARVE]));

  assert_in_swap_R4: assert property (@(posedge clk) disable iff (rst)
    done_v[DIR_IN] |=> (in_nxt == '0 && flags[FB_IN_DONE] && in_addr == in_cur));

  assert_out_swap_R4: assert property (@(posedge clk) disable iff (rst)
    done_v[DIR_OUT] |=> (out_nxt == '0 && flags[FB_OUT_DONE] && out_addr == out_cur));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!running && !reg_we) |=> ($stable(in_addr) && $stable(out_addr)));

  assert_irq_R10: assert property (@(posedge clk) disable iff (rst)
    irq == |(flags & mask));

endmodule

bind bufptr_ctrl bufptr_ctrl_chk #(.AW(AW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .reg_we  (reg_we),
  .running (running),
  .kill    (kill),
  .done_v  (done_v),
  .in_cur  (cur_v[0]),
  .out_cur (cur_v[1]),
  .in_nxt  (nxt_v[0]),
  .out_nxt (nxt_v[1]),
  .in_addr (in_addr),
  .out_addr(out_addr),
  .flags   (flags),
  .mask    (mask),
  .irq     (irq)
);

// File: tb/bufptr_ctrl_test.sv
module bufptr_ctrl_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        frame_tick = 1'b0;
  logic        err_fclk = 1'b0, err_bus = 1'b0, err_timeout = 1'b0;
  logic [31:0] in_addr, out_addr;
  logic        running, irq;

  int nvec = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  bufptr_ctrl uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_tick(frame_tick),
    .err_fclk(err_fclk), .err_bus(err_bus), .err_timeout(err_timeout),
    .in_addr(in_addr), .out_addr(out_addr), .running(running), .irq(irq)
  );

  function automatic logic [31:0] step_of(input int ch, input int wide);
    return 32'(ch * (wide != 0 ? 3 : 2));
  endfunction

  function automatic logic [31:0] fmt_of(input int ich, input int och, input int wide);
    return 32'(ich) | (32'(och) << 4) | (32'(wide) << 8);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wr_frame(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; frame_tick = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; frame_tick = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic frame();
    @(negedge clk);
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    chk("R1 running", {31'b0, running}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 in_addr", in_addr, 0);
    rd(4'd0, v); chk("R1 length", v, 0);
    rd(4'd4, v); chk("R1 in cur", v, 0);
    rd(4'd6, v); chk("R1 flags", v, 0);
    rd(4'd7, v); chk("R1 mask", v, 0);

    // Directed: inbound 2 ch x 2 bytes, outbound idle
    wr(4'd1, fmt_of(2, 0, 0));
    wr(4'd2, 32'h100);
    wr(4'd3, 32'h700);
    wr(4'd0, 32'd2);
    chk("R2 in_addr", in_addr, 32'h100);
    chk("R2 running", {31'b0, running}, 1);
    rd(4'd2, v); chk("R2 in next cleared", v, 0);
    rd(4'd5, v); chk("R2 out cur", v, 32'h700);
    frame();
    chk("R3 in step", in_addr, 32'h104);
    chk("R6 out idle", out_addr, 32'h700);
    wr_frame(4'd2, 32'h200);  // refill lands on the ending strobe
    chk("R4 same-cycle swap", in_addr, 32'h200);
    rd(4'd4, v); chk("R4 in cur", v, 32'h200);
    rd(4'd2, v); chk("R4 in next", v, 0);
    rd(4'd6, v); chk("R4 in done flag", v, 32'h20);
    frame();
    chk("R3 in step 2", in_addr, 32'h204);
    wr_frame(4'd8, 32'h21);   // starve while clearing bit0 and bit5
    rd(4'd6, v); chk("R9 set beats clear", v, 32'h01);
    chk("R5 running", {31'b0, running}, 0);
    chk("R5 in_addr", in_addr, 0);
    chk("R5 out_addr", out_addr, 0);
    rd(4'd4, v); chk("R5 in cur", v, 0);
    rd(4'd5, v); chk("R5 out cur", v, 0);
    rd(4'd3, v); chk("R5 out next", v, 0);
    rd(4'd0, v); chk("R5 length", v, 0);

    // R10 masking
    chk("R10 irq masked off", {31'b0, irq}, 0);
    rd(4'd9, v); chk("R10 masked zero", v, 0);
    wr(4'd7, 32'h01);
    chk("R10 irq on", {31'b0, irq}, 1);
    rd(4'd9, v); chk("R10 masked", v, 32'h01);
    wr(4'd8, 32'h3f);
    chk("R10 irq off after clear", {31'b0, irq}, 0);
    rd(4'd6, v); chk("R9 cleared", v, 0);

    // R8 external events
    @(negedge clk) err_fclk = 1'b1;
    @(negedge clk) begin err_fclk = 1'b0; err_bus = 1'b1; end
    @(negedge clk) begin err_bus = 1'b0; err_timeout = 1'b1; end
    @(negedge clk) err_timeout = 1'b0;
    rd(4'd6, v); chk("R8 event flags", v, 32'h0e);
    wr(4'd8, 32'h3f);
    wr(4'd7, 32'h00);

    // R7 stop by zero length, 3-byte words
    wr(4'd1, fmt_of(1, 1, 1));
    wr(4'd2, 32'h1000);
    wr(4'd3, 32'h2000);
    wr(4'd0, 32'd4);
    frame();
    chk("R3 wide in", in_addr, 32'h1003);
    chk("R3 wide out", out_addr, 32'h2003);
    wr(4'd0, 32'd0);
    chk("R7 stopped", {31'b0, running}, 0);
    frame(); frame();
    chk("R7 in hold", in_addr, 32'h1003);
    chk("R7 out hold", out_addr, 32'h2003);
    rd(4'd6, v); chk("R7 no flags", v, 0);

    // Random runs ending in starvation
    for (int it = 0; it < 24; it++) begin
      int ich, och, wd, len, nb;
      logic [31:0] ib, ob, si, so, exp_flags;
      ich = $urandom_range(0, 4);
      och = $urandom_range(1, 4);
      wd  = $urandom_range(0, 1);
      len = $urandom_range(1, 5);
      nb  = $urandom_range(1, 3);
      si  = step_of(ich, wd);
      so  = step_of(och, wd);
      ib  = 32'h1000_0000 + (32'(it) << 16);
      ob  = 32'h2000_0000 + (32'(it) << 16);
      wr(4'd1, fmt_of(ich, och, wd));
      wr(4'd2, ib);
      wr(4'd3, ob);
      wr(4'd0, 32'(len));
      for (int b = 0; b < nb; b++) begin
        if (b < nb - 1) begin
          wr(4'd2, ib + (32'(b + 1) << 12));
          wr(4'd3, ob + (32'(b + 1) << 12));
        end
        for (int k = 0; k < len; k++) begin
          chk("R3 rand in", in_addr,
              (ich != 0) ? ib + (32'(b) << 12) + 32'(k) * si : ib);
          chk("R4 rand out", out_addr, ob + (32'(b) << 12) + 32'(k) * so);
          frame();
        end
      end
      chk("R5 rand stop", {31'b0, running}, 0);
      chk("R5 rand in zero", in_addr, 0);
      chk("R5 rand out zero", out_addr, 0);
      exp_flags = 32'h1 | ((nb > 1) ? 32'h10 : 0) | ((nb > 1 && ich != 0) ? 32'h20 : 0);
      rd(4'd6, v); chk("R4 rand flags", v, exp_flags);
      wr(4'd8, 32'h3f);
    end

    summary();
  end

endmodule